// File: doc/BRIEF.md
# Edge-counted delayed glitch pulse generator

The block arms on a programmed number of rising edges seen on an asynchronous trigger input. When the last edge arrives, it waits a programmed offset, drives one pulse of programmed width, and then holds an auxiliary cut output high through a fixed guard interval. Once the guard interval ends, it raises a completion interrupt and stays there until the interrupt is acknowledged. It then returns to the start and takes a fresh set of parameters.

Parameters arrive one word per handshake on a valid/ready word port, in a fixed order. The edge count comes first and the offset second; both are taken before the block starts looking at the trigger. The width word is requested only after the final trigger edge. Each loaded count N stands for N+1 units.

The two outputs together form a two-bit code, {cut_out, pulse_out}:
- 00 while loading, counting edges and done.
- 10 during the offset.
- 11 during the pulse.
- 10 during the guard interval.

Top module: `glitch_pulse_gen`

## Requirements
- R1: After reset, pulse_out, cut_out and done_irq are 0 and cfg_ready is 1, waiting for the edge-count word.
- R2: The first accepted word is the edge count and the second is the offset. With no cfg_valid, the block stays in the same load step with cfg_ready high and both outputs low.
- R3: A loaded edge count N needs N+1 low-to-high transitions of the synchronized trigger before the width word is requested (cfg_ready rises). A trigger that is already high when counting starts does not count until it has been seen low.
- R4: In the cycle after the width word is accepted, the code becomes 10 (cut_out=1, pulse_out=0). It holds for exactly O+1 cycles, where O is the loaded offset.
- R5: Right after the offset, the code is 11 for exactly W+1 cycles, where W is the loaded width.
- R6: Right after the pulse, the code is 10 for exactly 1312 cycles, which is 32 rounds of 41 cycles.
- R7: done_irq rises in the first cycle after the guard interval, with the code at 00 and cfg_ready low. It stays high for as long as irq_clear is low.
- R8: irq_clear while done_irq is high clears done_irq on the next cycle and re-arms the block: cfg_ready is 1 and the next word taken is an edge count.
- R9: The code 01 (pulse_out high with cut_out low) never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every count unit is one cycle |
| rst | input | 1 | Synchronous active-high reset |
| cfg_data | input | 32 | Parameter word |
| cfg_valid | input | 1 | Parameter word present |
| cfg_ready | output | 1 | Block takes a word this cycle when cfg_valid is high |
| trig_in | input | 1 | Asynchronous trigger, passed through two flops |
| irq_clear | input | 1 | Acknowledge for done_irq |
| pulse_out | output | 1 | Pulse output, code bit 0 |
| cut_out | output | 1 | Auxiliary enable-cut output, code bit 1 |
| done_irq | output | 1 | Completion interrupt |

## Verification
A trigger rise driven between clock edges reaches the edge counter after two synchronizer flops and one state step. cfg_ready for the width word is therefore due within three clock edges of the final rise. The bench holds each trigger level for four cycles and samples cfg_ready only after the high phase has ended.

The outputs are decoded straight from the state register. The first 10 cycle is therefore the one right after the accepting edge, and the bench counts the runs of 10, 11 and 10 at falling edges from that point. Each run length is compared with O+1, W+1 and 1312. done_irq is checked in the cycle the last run ends, and it is checked again one cycle after irq_clear is sampled.

// File: rtl/gpg_pkg.sv
package gpg_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [3:0] {
        ST_LD_EDGES,
        ST_LD_OFS,
        ST_ARM_LOW,
        ST_ARM_HIGH,
        ST_LD_WID,
        ST_OFFSET,
        ST_PULSE,
        ST_GUARD,
        ST_DONE
    } gpg_state_e;

    typedef struct packed {
        logic cut;
        logic pulse;
    } gpg_code_t;

    // Output code owned by each state
    function automatic gpg_code_t code_of(gpg_state_e s);
        gpg_code_t c;
        c = '{cut: 1'b0, pulse: 1'b0};
        case (s)
            ST_OFFSET: c = '{cut: 1'b1, pulse: 1'b0};
            ST_PULSE:  c = '{cut: 1'b1, pulse: 1'b1};
            ST_GUARD:  c = '{cut: 1'b1, pulse: 1'b0};
            default:   c = '{cut: 1'b0, pulse: 1'b0};
        endcase
        return c;
    endfunction

    // States that take a parameter word
    function automatic logic wants_word(gpg_state_e s);
        return (s == ST_LD_EDGES) || (s == ST_LD_OFS) || (s == ST_LD_WID);
    endfunction

endpackage

// File: rtl/gpg_sync.sv
module gpg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[i] <= 1'b0;
                end else if (i == 0) begin
                    chain[i] <= d_async;
                end else begin
                    chain[i] <= chain[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/gpg_fsm.sv
module gpg_fsm
    import gpg_pkg::*;
#(
    parameter int CW                = WORD_W,
    parameter int GUARD_ITERS       = 32,
    parameter int GUARD_ITER_CYCLES = 41
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] word,
    input  logic          word_valid,
    output logic          word_ready,
    input  logic          trig_s,
    input  logic          irq_clear,
    output gpg_state_e    state,
    output logic          irq
);
    localparam int GUARD_TOTAL = GUARD_ITERS * GUARD_ITER_CYCLES;
    localparam int GW          = $clog2(GUARD_TOTAL);
    localparam logic [GW-1:0] GUARD_LOAD = GW'(GUARD_TOTAL - 1);

    logic [CW-1:0] edge_cnt;
    logic [CW-1:0] ofs_cnt;
    logic [CW-1:0] wid_cnt;
    logic [GW-1:0] guard_cnt;
    logic          take;

    assign word_ready = wants_word(state);
    assign take       = word_ready && word_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_LD_EDGES;
            edge_cnt  <= '0;
            ofs_cnt   <= '0;
            wid_cnt   <= '0;
            guard_cnt <= '0;
            irq       <= 1'b0;
        end else begin
            case (state)
                ST_LD_EDGES: begin
                    if (take) begin
                        edge_cnt <= word;
                        state    <= ST_LD_OFS;
                    end
                end
                ST_LD_OFS: begin
                    if (take) begin
                        ofs_cnt <= word;
                        irq     <= 1'b0;     // drop any stale completion flag
                        state   <= ST_ARM_LOW;
                    end
                end
                ST_ARM_LOW: begin
                    if (!trig_s) state <= ST_ARM_HIGH;
                end
                ST_ARM_HIGH: begin
                    if (trig_s) begin
                        if (edge_cnt == '0) begin
                            state <= ST_LD_WID;
                        end else begin
                            edge_cnt <= edge_cnt - 1'b1;
                            state    <= ST_ARM_LOW;
                        end
                    end
                end
                ST_LD_WID: begin
                    if (take) begin
                        wid_cnt <= word;
                        state   <= ST_OFFSET;
                    end
                end
                ST_OFFSET: begin
                    if (ofs_cnt == '0) state <= ST_PULSE;
                    else               ofs_cnt <= ofs_cnt - 1'b1;
                end
                ST_PULSE: begin
                    if (wid_cnt == '0) begin
                        guard_cnt <= GUARD_LOAD;
                        state     <= ST_GUARD;
                    end else begin
                        wid_cnt <= wid_cnt - 1'b1;
                    end
                end
                ST_GUARD: begin
                    if (guard_cnt == '0) begin
                        irq   <= 1'b1;
                        state <= ST_DONE;
                    end else begin
                        guard_cnt <= guard_cnt - 1'b1;
                    end
                end
                ST_DONE: begin
                    if (irq_clear) begin
                        irq   <= 1'b0;
                        state <= ST_LD_EDGES;
                    end
                end
                default: state <= ST_LD_EDGES;
            endcase
        end
    end
endmodule

// File: rtl/gpg_encode.sv
module gpg_encode
    import gpg_pkg::*;
(
    input  gpg_state_e state,
    output logic       pulse_o,
    output logic       cut_o
);
    gpg_code_t code;

    always_comb begin
        code    = code_of(state);
        pulse_o = code.pulse;
        cut_o   = code.cut;
    end
endmodule

// File: rtl/glitch_pulse_gen.sv
module glitch_pulse_gen
    import gpg_pkg::*;
#(
    parameter int CW                = WORD_W,
    parameter int SYNC_STAGES       = 2,
    parameter int GUARD_ITERS       = 32,
    parameter int GUARD_ITER_CYCLES = 41
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cfg_data,
    input  logic          cfg_valid,
    output logic          cfg_ready,
    input  logic          trig_in,
    input  logic          irq_clear,
    output logic          pulse_out,
    output logic          cut_out,
    output logic          done_irq
);
    logic       trig_s;
    gpg_state_e state;

    gpg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (trig_in),
        .q_sync  (trig_s)
    );

    gpg_fsm #(
        .CW                (CW),
        .GUARD_ITERS       (GUARD_ITERS),
        .GUARD_ITER_CYCLES (GUARD_ITER_CYCLES)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .word       (cfg_data),
        .word_valid (cfg_valid),
        .word_ready (cfg_ready),
        .trig_s     (trig_s),
        .irq_clear  (irq_clear),
        .state      (state),
        .irq        (done_irq)
    );

    gpg_encode u_enc (
        .state   (state),
        .pulse_o (pulse_out),
        .cut_o   (cut_out)
    );
endmodule

// File: rtl/gpg_checker.sv
module gpg_checker
    import gpg_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cfg_valid,
    input logic       cfg_ready,
    input logic       irq_clear,
    input logic       pulse_out,
    input logic       cut_out,
    input logic       done_irq,
    input gpg_state_e st
);
    // R9
    a_r9_no_pulse_without_cut: assert property (@(posedge clk) disable iff (rst)
        pulse_out |-> cut_out);

    // R4
    a_r4_offset_after_width: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid && cfg_ready && st == ST_LD_WID) |=> (cut_out && !pulse_out));

    // R6
    a_r6_guard_follows_pulse: assert property (@(posedge clk) disable iff (rst)
        $fell(pulse_out) |-> cut_out);

    // R7
    a_r7_irq_holds: assert property (@(posedge clk) disable iff (rst)
        (done_irq && !irq_clear) |=> done_irq);

    // R7
    a_r7_quiet_when_done: assert property (@(posedge clk) disable iff (rst)
        done_irq |-> (!cut_out && !pulse_out && !cfg_ready));

    // R8
    a_r8_rearm: assert property (@(posedge clk) disable iff (rst)
        (done_irq && irq_clear) |=> (!done_irq && cfg_ready));
endmodule

bind glitch_pulse_gen gpg_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_valid (cfg_valid),
    .cfg_ready (cfg_ready),
    .irq_clear (irq_clear),
    .pulse_out (pulse_out),
    .cut_out   (cut_out),
    .done_irq  (done_irq),
    .st        (state)
);

// File: tb/glitch_pulse_gen_bench.sv
module glitch_pulse_gen_bench;
    localparam int GUARD_LEN = 1312;
    localparam int NVEC      = 5;
    // {edges, offset, width}
    localparam logic [95:0] VEC [NVEC] = '{
        {32'd0, 32'd0,  32'd0},
        {32'd2, 32'd5,  32'd3},
        {32'd1, 32'd0,  32'd7},
        {32'd3, 32'd12, 32'd0},
        {32'd0, 32'd9,  32'd1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_data = '0;
    logic        cfg_valid = 1'b0;
    logic        cfg_ready;
    logic        trig_in = 1'b0;
    logic        irq_clear = 1'b0;
    logic        pulse_out, cut_out, done_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    glitch_pulse_gen u_glitch_pulse_gen (
        .clk (clk), .rst (rst), .cfg_data (cfg_data), .cfg_valid (cfg_valid),
        .cfg_ready (cfg_ready), .trig_in (trig_in), .irq_clear (irq_clear),
        .pulse_out (pulse_out), .cut_out (cut_out), .done_irq (done_irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic send_word(input logic [31:0] w);
        int guard_n = 0;
        while (!cfg_ready && guard_n < 50) begin
            @(negedge clk);
            guard_n++;
        end
        cfg_data  = w;
        cfg_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    task automatic trig_edge();
        trig_in = 1'b0;
        repeat (4) @(negedge clk);
        trig_in = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // From the edge that took the width word: measure the runs and the completion
    task automatic measure(input int ofs, input int wid, input string id);
        int n;
        cfg_data  = 32'(wid);
        cfg_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cfg_valid = 1'b0;
        n = 0;
        while (cut_out && !pulse_out && n < 100000) begin n++; @(negedge clk); end
        check({"R4 offset run ", id}, n, ofs + 1);
        n = 0;
        while (pulse_out && n < 100000) begin
            if (!cut_out) check({"R9 code 01 ", id}, 0, 1);
            n++; @(negedge clk);
        end
        check({"R5 pulse run ", id}, n, wid + 1);
        n = 0;
        while (cut_out && !pulse_out && n < 100000) begin n++; @(negedge clk); end
        check({"R6 guard run ", id}, n, GUARD_LEN);
        check({"R7 irq at guard end ", id}, int'(done_irq), 1);
        check({"R7 code 00 when done ", id}, int'({cut_out, pulse_out}), 0);
        repeat (10) @(negedge clk);
        check({"R7 irq held ", id}, int'(done_irq), 1);
        check({"R7 ready low when done ", id}, int'(cfg_ready), 0);
        irq_clear = 1'b1;
        @(posedge clk);
        @(negedge clk);
        irq_clear = 1'b0;
        check({"R8 irq cleared ", id}, int'(done_irq), 0);
        check({"R8 rearmed ready ", id}, int'(cfg_ready), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset pulse", int'(pulse_out), 0);
        check("R1 reset cut", int'(cut_out), 0);
        check("R1 reset irq", int'(done_irq), 0);
        check("R1 reset ready", int'(cfg_ready), 1);

        // R2: stall with no word offered
        repeat (20) @(negedge clk);
        check("R2 stall ready", int'(cfg_ready), 1);
        check("R2 stall outputs", int'({cut_out, pulse_out}), 0);

        for (int v = 0; v < NVEC; v++) begin
            automatic int e = int'(VEC[v][95:64]);
            automatic int o = int'(VEC[v][63:32]);
            automatic int w = int'(VEC[v][31:0]);
            automatic string id = $sformatf("vec%0d", v);
            send_word(32'(e));
            check({"R2 offset word wanted ", id}, int'(cfg_ready), 1);
            send_word(32'(o));
            for (int k = 0; k <= e; k++) begin
                trig_edge();
                if (k < e) begin
                    check({"R3 no width request early ", id}, int'(cfg_ready), 0);
                    check({"R3 outputs idle while counting ", id}, int'(cut_out), 0);
                end
            end
            check({"R3 width request after last edge ", id}, int'(cfg_ready), 1);
            measure(o, w, id);
        end

        // R3: trigger already high at arm start is not an edge
        trig_in = 1'b1;
        repeat (4) @(negedge clk);
        send_word(32'd0);
        send_word(32'd2);
        repeat (12) @(negedge clk);
        check("R3 high trigger not counted", int'(cfg_ready), 0);
        trig_edge();
        check("R3 edge after low counted", int'(cfg_ready), 1);
        measure(2, 4, "hi_start");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule